// File: doc/BRIEF.md
# Real-Time Clock Alarm Match Flag

This block watches the running time of a real-time clock (subsecond, second, minute and hour) and compares it against a set of alarm values. Each of the four fields has its own compare enable. A field whose enable is low is left out of the comparison. An alarm event occurs when every enabled field equals its alarm value at the same time, and at least one enable is high.

The event sets a sticky interrupt flag. The flag raises an interrupt request while the external interrupt enable input is high. Software clears the flag through a control register write port once it has serviced the interrupt. Software can never set the flag. Turning off all four compare enables force-clears it.

The flag responds to the onset of a match, not to its level. A match that is still present after software clears the flag does not set it again. The time counters and the interrupt controller sit outside this block.

Top module: `rtc_alarm_flag`

## Requirements
- R1: When all enabled fields first equal their alarm values, with at least one enable high, the flag reads 1 after the next rising clock edge.
- R2: A field whose compare enable is 0 does not affect the match. Compare enable index 0 selects the subsecond field, 1 the seconds field, 2 the minutes field and 3 the hours field. These correspond to control bits 4 to 7.
- R3: The interrupt request is high exactly while the flag is 1 and `irq_en` is 1. It follows `irq_en` in the same cycle, with no register in between.
- R4: A control write (`ctl_we` = 1) with bit 1 of `ctl_wdata` equal to 0 clears the flag at the next edge. A write with bit 1 equal to 1 leaves the flag unchanged, so it never sets the flag and never raises a request. The other bits of `ctl_wdata` are ignored by this block.
- R5: While all four compare enables are 0, the flag is 0 after each edge and cannot be set.
- R6: A match that persists after the flag has been cleared does not set it again. The flag sets again only after the match condition has dropped and then returned.
- R7: If a clearing write and the onset of a match fall on the same edge, the flag is 1 after that edge.
- R8: The synchronous `rst` input, which models loss of backup power, clears the flag and the match history. A match present when `rst` is released counts as a new onset at the first edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-loss reset |
| ss_now | input | 8 | Current subsecond count |
| sec_now | input | 6 | Current seconds |
| min_now | input | 6 | Current minutes |
| hr_now | input | 5 | Current hours |
| ss_alm | input | 8 | Subsecond alarm value |
| sec_alm | input | 6 | Seconds alarm value |
| min_alm | input | 6 | Minutes alarm value |
| hr_alm | input | 5 | Hours alarm value |
| cmp_en | input | 4 | Per-field compare enables, index 0 = subsecond to index 3 = hours |
| irq_en | input | 1 | Interrupt enable from the interrupt controller |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data; bit 1 is the flag |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Interrupt request |

## Verification
The flag passes through exactly one register, so any change in time, enables or write data shows on `alarm_flag` after the next rising edge. The request, in contrast, reacts to `irq_en` within the same cycle. The driver applies each stimulus just after a rising edge and queues two expected items for the monitor to compare at falling edges. The first is the request that is due in that same cycle, computed from the old flag. The second is the flag and request due one edge later, computed by a reference model. The write strobe lasts one edge only, and each stimulus is then held for extra edges. This isolates same-edge cases such as a clear racing a new match.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int SS_W     = 8;
    localparam int SEC_W    = 6;
    localparam int MIN_W    = 6;
    localparam int HR_W     = 5;
    localparam int NFIELD   = 4;
    localparam int CTL_W    = 8;
    localparam int FLAG_BIT = 1;
    localparam int TIME_W   = SS_W + SEC_W + MIN_W + HR_W;

    typedef struct packed {
        logic [HR_W-1:0]  hr;
        logic [MIN_W-1:0] mn;
        logic [SEC_W-1:0] sec;
        logic [SS_W-1:0]  ss;
    } rtc_time_t;

    typedef enum logic [1:0] {
        FLD_SS  = 2'd0,
        FLD_SEC = 2'd1,
        FLD_MIN = 2'd2,
        FLD_HR  = 2'd3
    } field_e;

    typedef enum logic [1:0] {
        FLAG_HOLD  = 2'd0,
        FLAG_SET   = 2'd1,
        FLAG_CLEAR = 2'd2
    } flag_op_e;

    function automatic int field_width(input int idx);
        case (idx)
            0:       return SS_W;
            1:       return SEC_W;
            2:       return MIN_W;
            default: return HR_W;
        endcase
    endfunction

    function automatic int field_lsb(input int idx);
        int acc;
        acc = 0;
        for (int k = 0; k < idx; k++) begin
            acc += field_width(k);
        end
        return acc;
    endfunction

    function automatic logic any_enabled(input logic [NFIELD-1:0] en);
        return |en;
    endfunction

endpackage

// File: rtl/rtc_field_cmp.sv
module rtc_field_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] alm,
    input  logic         en,
    output logic         hit
);
    // A disabled field never blocks the overall match.
    always_comb begin
        hit = (!en) || (cur == alm);
    end
endmodule

// File: rtl/rtc_match_detect.sv
module rtc_match_detect
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rtc_time_t         now,
    input  rtc_time_t         alm,
    input  logic [NFIELD-1:0] en,
    output logic              match_all,
    output logic              match_rise
);
    logic [TIME_W-1:0] now_vec;
    logic [TIME_W-1:0] alm_vec;
    logic [NFIELD-1:0] hits;
    logic              match_q;

    assign now_vec = now;
    assign alm_vec = alm;

    for (genvar f = 0; f < NFIELD; f++) begin : g_field
        localparam int FW = field_width(f);
        localparam int LO = field_lsb(f);
        rtc_field_cmp #(.W(FW)) u_cmp (
            .cur (now_vec[LO +: FW]),
            .alm (alm_vec[LO +: FW]),
            .en  (en[f]),
            .hit (hits[f])
        );
    end

    always_comb begin
        match_all  = (&hits) && any_enabled(en);
        match_rise = match_all && !match_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= 1'b0;
        end else begin
            match_q <= match_all;
        end
    end

    // R6: an onset lasts one cycle; a held match yields no second onset
    p_single_rise_r6: assert property (@(posedge clk) disable iff (rst)
        match_rise |=> !match_rise);

endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SS_W-1:0]   ss_now,
    input  logic [SEC_W-1:0]  sec_now,
    input  logic [MIN_W-1:0]  min_now,
    input  logic [HR_W-1:0]   hr_now,
    input  logic [SS_W-1:0]   ss_alm,
    input  logic [SEC_W-1:0]  sec_alm,
    input  logic [MIN_W-1:0]  min_alm,
    input  logic [HR_W-1:0]   hr_alm,
    input  logic [NFIELD-1:0] cmp_en,
    input  logic              irq_en,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic              alarm_flag,
    output logic              alarm_irq
);
    rtc_time_t now_t;
    rtc_time_t alm_t;
    logic      match_all;
    logic      match_rise;
    logic      sw_clear;
    flag_op_e  flag_op;
    logic      flag_q;

    always_comb begin
        now_t = '{hr: hr_now, mn: min_now, sec: sec_now, ss: ss_now};
        alm_t = '{hr: hr_alm, mn: min_alm, sec: sec_alm, ss: ss_alm};
    end

    rtc_match_detect u_detect (
        .clk        (clk),
        .rst        (rst),
        .now        (now_t),
        .alm        (alm_t),
        .en         (cmp_en),
        .match_all  (match_all),
        .match_rise (match_rise)
    );

    // Software may only write a zero to the flag; a one is discarded.
    assign sw_clear = ctl_we && !ctl_wdata[FLAG_BIT];

    always_comb begin
        if (!any_enabled(cmp_en)) begin
            flag_op = FLAG_CLEAR;
        end else if (match_rise) begin
            flag_op = FLAG_SET;
        end else if (sw_clear) begin
            flag_op = FLAG_CLEAR;
        end else begin
            flag_op = FLAG_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            case (flag_op)
                FLAG_SET:   flag_q <= 1'b1;
                FLAG_CLEAR: flag_q <= 1'b0;
                default:    flag_q <= flag_q;
            endcase
        end
    end

    assign alarm_flag = flag_q;
    assign alarm_irq  = flag_q && irq_en;

    // R1: the flag only rises after a match onset
    p_set_on_rise_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(match_rise));

    // R3: no request without the enable
    p_irq_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
        alarm_irq |-> irq_en);

    // R4: a zero write with no onset clears the flag
    p_sw_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (sw_clear && !match_rise) |=> !flag_q);

    // R4: nothing but an onset can turn a clear flag on
    p_sw_noset_r4: assert property (@(posedge clk) disable iff (rst)
        (!flag_q && !match_rise) |=> !flag_q);

    // R5: all enables off forces the flag low
    p_all_off_r5: assert property (@(posedge clk) disable iff (rst)
        (cmp_en == '0) |=> !flag_q);

    // R7: an onset beats a same-edge clear
    p_clear_race_r7: assert property (@(posedge clk) disable iff (rst)
        (sw_clear && match_rise) |=> flag_q);

endmodule

// File: tb/rtc_alarm_flag_bench.sv
module rtc_alarm_flag_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] ss_now = '0, ss_alm = 8'd5;
    logic [5:0] sec_now = '0, sec_alm = 6'd10;
    logic [5:0] min_now = '0, min_alm = 6'd20;
    logic [4:0] hr_now = '0, hr_alm = 5'd7;
    logic [3:0] cmp_en = '0;
    logic       irq_en = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       alarm_flag, alarm_irq;

    rtc_alarm_flag u_rtc_alarm_flag (
        .clk(clk), .rst(rst),
        .ss_now(ss_now), .sec_now(sec_now), .min_now(min_now), .hr_now(hr_now),
        .ss_alm(ss_alm), .sec_alm(sec_alm), .min_alm(min_alm), .hr_alm(hr_alm),
        .cmp_en(cmp_en), .irq_en(irq_en), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
    );

    always #2 clk = ~clk;

    typedef struct {
        int    due;
        bit    flag;
        bit    irq;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   m_flag = 0;
    bit   m_prev = 0;
    bit   finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare due items away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            n_checks++;
            if (alarm_flag !== e.flag || alarm_irq !== e.irq) begin
                n_fail++;
                $display("FAIL %s: flag/irq actual %b/%b expected %b/%b (cycle %0d)",
                         e.tag, alarm_flag, alarm_irq, e.flag, e.irq, cyc);
            end
        end
    end

    task automatic do_reset(input string tag);
        @(posedge clk); #1;
        rst = 1'b1;
        m_flag = 0;
        m_prev = 0;
        q.push_back('{cyc + 1, 1'b0, 1'b0, tag});
        @(posedge clk);
        @(posedge clk);
    endtask

    task automatic step(input logic [7:0] ss, input logic [5:0] sc,
                        input logic [5:0] mn, input logic [4:0] hr,
                        input logic [3:0] en, input bit ie,
                        input bit we, input logic [7:0] wd, input string tag);
        bit m, rise;
        @(posedge clk); #1;
        rst = 1'b0;
        ss_now = ss; sec_now = sc; min_now = mn; hr_now = hr;
        cmp_en = en; irq_en = ie; ctl_we = we; ctl_wdata = wd;
        // request due this cycle from the old flag
        q.push_back('{cyc, m_flag, m_flag & ie, tag});
        m = (!en[0] || ss == ss_alm) && (!en[1] || sc == sec_alm) &&
            (!en[2] || mn == min_alm) && (!en[3] || hr == hr_alm) && (en != 0);
        rise = m && !m_prev;
        if (en == 0)              m_flag = 0;
        else if (rise)            m_flag = 1;
        else if (we && !wd[1])    m_flag = 0;
        m_prev = m;
        q.push_back('{cyc + 1, m_flag, m_flag & ie, tag});
        @(posedge clk); #1;
        ctl_we = 1'b0;
    endtask

    initial begin
        do_reset("R8");
        // R1: subsecond only enabled, no match yet
        step(8'd3, 6'd0, 6'd0, 5'd0, 4'b0001, 0, 0, 8'h00, "R1");
        // R2: seconds differ but are disabled; flag sets
        step(8'd5, 6'd33, 6'd1, 5'd2, 4'b0001, 0, 0, 8'h00, "R2");
        // R3: enable request, same-cycle response
        step(8'd5, 6'd33, 6'd1, 5'd2, 4'b0001, 1, 0, 8'h00, "R3");
        step(8'd5, 6'd33, 6'd1, 5'd2, 4'b0001, 0, 0, 8'h00, "R3");
        // R4: writing a one leaves the flag set
        step(8'd5, 6'd33, 6'd1, 5'd2, 4'b0001, 1, 1, 8'hFF, "R4");
        // R4/R6: clear while the match persists; no re-set
        step(8'd5, 6'd33, 6'd1, 5'd2, 4'b0001, 1, 1, 8'h00, "R4");
        step(8'd5, 6'd33, 6'd1, 5'd2, 4'b0001, 1, 0, 8'h00, "R6");
        // R4: a one written to a clear flag does not set it
        step(8'd5, 6'd33, 6'd1, 5'd2, 4'b0001, 1, 1, 8'h02, "R4");
        // R6: match drops, then returns
        step(8'd6, 6'd33, 6'd1, 5'd2, 4'b0001, 1, 0, 8'h00, "R6");
        step(8'd5, 6'd33, 6'd1, 5'd2, 4'b0001, 1, 0, 8'h00, "R6");
        // R5: all enables off clears the flag despite the matching time
        step(8'd5, 6'd33, 6'd1, 5'd2, 4'b0000, 1, 0, 8'h00, "R5");
        step(8'd5, 6'd10, 6'd20, 5'd7, 4'b0000, 1, 0, 8'h00, "R5");
        // R1: every field enabled and matching
        step(8'd5, 6'd10, 6'd20, 5'd7, 4'b1111, 1, 0, 8'h00, "R1");
        // R2: hours mismatch blocks, clear the flag
        step(8'd5, 6'd10, 6'd20, 5'd8, 4'b1111, 1, 1, 8'h00, "R2");
        // R2: hours disabled, remaining fields match -> onset
        step(8'd5, 6'd10, 6'd20, 5'd8, 4'b0111, 0, 0, 8'h00, "R2");
        step(8'd5, 6'd10, 6'd20, 5'd8, 4'b1111, 1, 1, 8'h00, "R2");
        // R7: clear and new onset on the same edge
        step(8'd5, 6'd10, 6'd20, 5'd7, 4'b1111, 1, 1, 8'h00, "R7");
        // R8: reset with a persistent match, then onset after release
        do_reset("R8");
        step(8'd5, 6'd10, 6'd20, 5'd7, 4'b1111, 1, 0, 8'h00, "R8");
        repeat (3) @(posedge clk);
        @(negedge clk);
        if (q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL scoreboard: %0d items left, expected 0", q.size());
        end
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        end
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule